// File: doc/BRIEF.md
# Configured-Instruction ALU Sequencer

This block is a 16-bit arithmetic/logic unit that takes its operation from a small table of preloaded instructions rather than from an instruction stream. Each instruction holds an opcode, a condition that can suppress execution, and four candidate successor slots. A two-bit branch index picks one of the four each cycle. The instruction in the active slot is decoded, executed and retired in one clock edge. The result word and a cascadable carry/status bit are registered at that same edge.

Operands arrive as 21-bit words: data in bits [15:0], valid in bit 16 and four sideband control bits in bits [20:17]. The table is written through a configuration port while the run enable is low. Holding run low also parks the sequencer in slot 0, so execution always begins from slot 0.

Top module: `cfg_alu_seq`

## Requirements
- R1: After reset `resValid`, `resData`, `statusOut` and `curSlot` are all 0, and every table slot holds zero. A zero instruction never executes and always branches to slot 0.
- R2: A table slot is written with `cfgData` at `cfgAddr` on a clock edge where `cfgWe` is high and `runEn` is low. Writes attempted while `runEn` is high are ignored. Instruction layout: op [3:0], condSel [7:4], condInv [8], brLo [12:9], brHi [16:13], then four 3-bit successor fields for index 0 [19:17], index 1 [22:20], index 2 [25:23] and index 3 [28:26].
- R3: While `runEn` is low, each edge loads `curSlot` with 0 and clears `resValid`. The first edge with `runEn` high executes slot 0.
- R4: Arithmetic ops set status to the carry out. The codes are: 0 a+b, 1 a+b+status, 2 a−b with carry = no borrow (a+~b+1), and 3 a+~b+status.
- R5: Logic and select ops leave status unchanged. The codes are: 4 AND, 5 OR, 6 XOR, 7 select (b when status is 1, else a), and 12–15 pass a.
- R6: The shift amount is b[3:0]. Code 8 shifts left logically and code 9 shifts right logically; both set status to the last bit shifted out, or to 0 for a zero amount. Code 10 rotates left and code 11 rotates right; rotates leave status unchanged.
- R7: An instruction executes when the selected source bit XOR condInv is 1. If it does not execute, `resValid` is 0 after that edge and `resData` and `statusOut` hold their values.
- R8: On every running edge, whether the instruction executed or not, `curSlot` becomes the successor field chosen by {source(brHi), source(brLo)}.
- R9: The 4-bit source codes are: 0 constant 0, 1 constant 1, 2 a valid, 3 b valid, 4 registered status, 5 current result is zero, 6 current result MSB, 7 current carry, 8–11 a control bits 0–3, and 12–15 b control bits 0–3.
- R10: The operands presented before an edge determine `resData`, `resValid` and `statusOut` directly after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Execute enable; low allows table writes and parks in slot 0 |
| cfgWe | input | 1 | Table write strobe |
| cfgAddr | input | 3 | Table slot to write |
| cfgData | input | 29 | Instruction to write |
| aWord | input | 21 | Operand A word (data, valid, control) |
| bWord | input | 21 | Operand B word (data, valid, control) |
| resData | output | 16 | Registered result data |
| resValid | output | 1 | High for one cycle after an executed instruction |
| statusOut | output | 1 | Registered carry/status for cascading |
| curSlot | output | 3 | Active instruction slot |

## Verification
The assertions assume that the reset is held for at least one edge before the first check. They also assume that `runEn` is the only source of execution. With those assumptions, a cycle without `resValid` must leave data and status stable, and a low `runEn` must always return the unit to slot 0. The stimulus changes inputs only just after a rising edge and issues table writes only in gaps where `runEn` is low. The single exception is one deliberate write attempt while running, whose effect is then observed on `resData`.

// File: rtl/cfgalu_pkg.sv
package cfgalu_pkg;
  parameter int DATA_W = 16;
  parameter int CTRL_W = 4;
  parameter int SLOTS  = 8;
  parameter int NEXT_N = 4;
  parameter int SRC_W  = 4;
  parameter int OP_W   = 4;

  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int WORD_W    = DATA_W + 1 + CTRL_W;
  localparam int VALID_BIT = DATA_W;
  localparam int CTRL_LSB  = DATA_W + 1;
  localparam int SRC_N     = 2 ** SRC_W;

  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_ADDC = OP_W'(1);
  localparam logic [OP_W-1:0] OP_SUB  = OP_W'(2);
  localparam logic [OP_W-1:0] OP_SUBC = OP_W'(3);
  localparam logic [OP_W-1:0] OP_AND  = OP_W'(4);
  localparam logic [OP_W-1:0] OP_OR   = OP_W'(5);
  localparam logic [OP_W-1:0] OP_XOR  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_MUX  = OP_W'(7);
  localparam logic [OP_W-1:0] OP_SHL  = OP_W'(8);
  localparam logic [OP_W-1:0] OP_SHR  = OP_W'(9);
  localparam logic [OP_W-1:0] OP_ROL  = OP_W'(10);
  localparam logic [OP_W-1:0] OP_ROR  = OP_W'(11);

  typedef struct packed {
    logic [NEXT_N-1:0][SLOT_W-1:0] nextSlot;
    logic [SRC_W-1:0]              brHi;
    logic [SRC_W-1:0]              brLo;
    logic                          condInv;
    logic [SRC_W-1:0]              condSel;
    logic [OP_W-1:0]               op;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  typedef struct packed {
    logic            run;
    logic            exec;
    logic [OP_W-1:0] op;
  } dpStrobe_t;

  typedef struct packed {
    logic status;
    logic zero;
    logic msb;
    logic carry;
  } dpFlags_t;
endpackage

// File: rtl/cfgalu_table.sv
module cfgalu_table
  import cfgalu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrAddr,
  input  instr_t            wrData,
  input  logic [SLOT_W-1:0] rdAddr,
  output instr_t            rdInstr
);
  instr_t slotMem [SLOTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) slotMem[s] <= '0;
    end else if (wrEn) begin
      slotMem[wrAddr] <= wrData;
    end
  end

  assign rdInstr = slotMem[rdAddr];
endmodule

// File: rtl/cfgalu_ctrl.sv
module cfgalu_ctrl
  import cfgalu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  instr_t            instr,
  input  logic              aValid,
  input  logic              bValid,
  input  logic [CTRL_W-1:0] aCtrl,
  input  logic [CTRL_W-1:0] bCtrl,
  input  dpFlags_t          flags,
  output logic [SLOT_W-1:0] slotQ,
  output dpStrobe_t         strobe
);
  logic [SRC_N-1:0] srcVec;
  logic             condBit;
  logic [1:0]       brIdx;

  always_comb begin
    srcVec  = {bCtrl, aCtrl, flags.carry, flags.msb, flags.zero, flags.status,
               bValid, aValid, 1'b1, 1'b0};
    condBit = srcVec[instr.condSel] ^ instr.condInv;
    brIdx   = {srcVec[instr.brHi], srcVec[instr.brLo]};
    strobe.run  = runEn;
    strobe.exec = condBit;
    strobe.op   = instr.op;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !runEn) slotQ <= '0;
    else                 slotQ <= instr.nextSlot[brIdx];
  end
endmodule

// File: rtl/cfgalu_dpath.sv
module cfgalu_dpath
  import cfgalu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] aData,
  input  logic [DATA_W-1:0] bData,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              statusOut,
  output dpFlags_t          flags
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]     shAmt;
  logic [DATA_W:0]     sumW, shlW, shrW, cinW, oneW;
  logic [2*DATA_W-1:0] rolW, rorW;
  logic [DATA_W-1:0]   aluRes;
  logic                aluCarry, setsStatus, statusQ, fire;

  always_comb begin
    shAmt = bData[SH_W-1:0];
    cinW  = {{DATA_W{1'b0}}, statusQ};
    oneW  = (DATA_W+1)'(1);
    shlW  = {1'b0, aData} << shAmt;
    shrW  = {aData, 1'b0} >> shAmt;
    rolW  = {aData, aData} << shAmt;
    rorW  = {aData, aData} >> shAmt;
    sumW  = '0;
    aluRes     = aData;
    aluCarry   = 1'b0;
    setsStatus = 1'b0;
    case (strobe.op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
        case (strobe.op)
          OP_ADD:  sumW = {1'b0, aData} + {1'b0, bData};
          OP_ADDC: sumW = {1'b0, aData} + {1'b0, bData} + cinW;
          OP_SUB:  sumW = {1'b0, aData} + {1'b0, ~bData} + oneW;
          default: sumW = {1'b0, aData} + {1'b0, ~bData} + cinW;
        endcase
        aluRes     = sumW[DATA_W-1:0];
        aluCarry   = sumW[DATA_W];
        setsStatus = 1'b1;
      end
      OP_AND: aluRes = aData & bData;
      OP_OR:  aluRes = aData | bData;
      OP_XOR: aluRes = aData ^ bData;
      OP_MUX: aluRes = statusQ ? bData : aData;
      OP_SHL: begin
        aluRes     = shlW[DATA_W-1:0];
        aluCarry   = shlW[DATA_W];
        setsStatus = 1'b1;
      end
      OP_SHR: begin
        aluRes     = shrW[DATA_W:1];
        aluCarry   = shrW[0];
        setsStatus = 1'b1;
      end
      OP_ROL: aluRes = rolW[2*DATA_W-1:DATA_W];
      OP_ROR: aluRes = rorW[DATA_W-1:0];
      default: aluRes = aData;
    endcase
    fire = strobe.run & strobe.exec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      resValid <= 1'b0;
      statusQ  <= 1'b0;
    end else begin
      resValid <= fire;
      if (fire) begin
        resData <= aluRes;
        if (setsStatus) statusQ <= aluCarry;
      end
    end
  end

  assign statusOut    = statusQ;
  assign flags.status = statusQ;
  assign flags.zero   = (aluRes == '0);
  assign flags.msb    = aluRes[DATA_W-1];
  assign flags.carry  = aluCarry;
endmodule

// File: rtl/cfg_alu_seq.sv
module cfg_alu_seq
  import cfgalu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic               cfgWe,
  input  logic [SLOT_W-1:0]  cfgAddr,
  input  logic [INSTR_W-1:0] cfgData,
  input  logic [WORD_W-1:0]  aWord,
  input  logic [WORD_W-1:0]  bWord,
  output logic [DATA_W-1:0]  resData,
  output logic               resValid,
  output logic               statusOut,
  output logic [SLOT_W-1:0]  curSlot
);
  instr_t    curInstr;
  dpStrobe_t strobe;
  dpFlags_t  flags;

  cfgalu_table i_table (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (cfgWe & ~runEn),
    .wrAddr  (cfgAddr),
    .wrData  (instr_t'(cfgData)),
    .rdAddr  (curSlot),
    .rdInstr (curInstr)
  );

  cfgalu_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .runEn  (runEn),
    .instr  (curInstr),
    .aValid (aWord[VALID_BIT]),
    .bValid (bWord[VALID_BIT]),
    .aCtrl  (aWord[CTRL_LSB +: CTRL_W]),
    .bCtrl  (bWord[CTRL_LSB +: CTRL_W]),
    .flags  (flags),
    .slotQ  (curSlot),
    .strobe (strobe)
  );

  cfgalu_dpath i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .aData     (aWord[DATA_W-1:0]),
    .bData     (bWord[DATA_W-1:0]),
    .resData   (resData),
    .resValid  (resValid),
    .statusOut (statusOut),
    .flags     (flags)
  );
endmodule

// File: rtl/cfgalu_chk.sv
module cfgalu_chk
  import cfgalu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic [DATA_W-1:0] resData,
  input logic              resValid,
  input logic              statusOut,
  input logic [SLOT_W-1:0] curSlot
);
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(resData));

  a_r7_hold_status: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(statusOut));

  a_r3_park_slot0: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (curSlot == '0 && !resValid));

  a_r3_valid_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(runEn));
endmodule

bind cfg_alu_seq cfgalu_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .runEn     (runEn),
  .resData   (resData),
  .resValid  (resValid),
  .statusOut (statusOut),
  .curSlot   (curSlot)
);

// File: tb/test_cfg_alu_seq.sv
module test_cfg_alu_seq;
  import cfgalu_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rstN, runEn, cfgWe;
  logic [SLOT_W-1:0]  cfgAddr;
  logic [INSTR_W-1:0] cfgData;
  logic [WORD_W-1:0]  aWord, bWord;
  logic [DATA_W-1:0]  resData;
  logic               resValid, statusOut;
  logic [SLOT_W-1:0]  curSlot;

  cfg_alu_seq i_cfg_alu_seq (.*);

  int nChecks = 0;
  int nFails  = 0;
  logic        mStatus = 1'b0;
  logic [15:0] mData   = '0;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic instr_t mkInstr(input int op, input int cs, input int ci,
                                     input int bh, input int bl,
                                     input int n0, input int n1, input int n2, input int n3);
    instr_t t;
    t.op = op[3:0]; t.condSel = cs[3:0]; t.condInv = ci[0];
    t.brHi = bh[3:0]; t.brLo = bl[3:0];
    t.nextSlot[0] = n0[2:0]; t.nextSlot[1] = n1[2:0];
    t.nextSlot[2] = n2[2:0]; t.nextSlot[3] = n3[2:0];
    return t;
  endfunction

  task automatic loadSlot(input int slot, input instr_t ins);
    cfgWe = 1'b1; cfgAddr = slot[2:0]; cfgData = ins;
    step();
    cfgWe = 1'b0;
  endtask

  // {setsStatus, carry, result}
  function automatic logic [17:0] aluModel(input logic [3:0] op, input logic [15:0] a,
                                           input logic [15:0] b, input logic st);
    logic [15:0] r; logic c; logic s; int n; logic [31:0] t;
    r = a; c = 1'b0; s = 1'b0; n = int'(b[3:0]);
    case (op)
      4'd0: begin t = 32'(a) + 32'(b); r = t[15:0]; c = t > 32'd65535; s = 1'b1; end
      4'd1: begin t = 32'(a) + 32'(b) + 32'(st); r = t[15:0]; c = t > 32'd65535; s = 1'b1; end
      4'd2: begin r = a - b; c = (a >= b); s = 1'b1; end
      4'd3: begin r = a - b - {15'b0, ~st}; c = (a > b) || ((a == b) && st); s = 1'b1; end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = st ? b : a;
      4'd8: begin r = a << n; c = (n == 0) ? 1'b0 : a[16-n]; s = 1'b1; end
      4'd9: begin r = a >> n; c = (n == 0) ? 1'b0 : a[n-1]; s = 1'b1; end
      4'd10: r = (n == 0) ? a : ((a << n) | (a >> (16 - n)));
      4'd11: r = (n == 0) ? a : ((a >> n) | (a << (16 - n)));
      default: r = a;
    endcase
    return {s, c, r};
  endfunction

  function automatic logic srcModel(input int code, input logic [20:0] aw, input logic [20:0] bw,
                                    input logic st, input logic [15:0] r, input logic c);
    case (code)
      0: return 1'b0;
      1: return 1'b1;
      2: return aw[16];
      3: return bw[16];
      4: return st;
      5: return r == 16'd0;
      6: return r[15];
      7: return c;
      default: return (code < 12) ? aw[17 + code - 8] : bw[17 + code - 12];
    endcase
  endfunction

  function automatic logic [15:0] patA(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'hFFFF; 2: return 16'h8000; 3: return 16'h7FFF;
      default: return 16'(i * 40503) ^ 16'h5A5A;
    endcase
  endfunction

  function automatic logic [15:0] patB(input int i);
    case (i)
      0: return 16'h0001; 1: return 16'hFFFF; 2: return 16'h8000; 3: return 16'h0000;
      default: return (16'(i * 26513 + 7) & 16'hFFF0) | 16'(i & 15);
    endcase
  endfunction

  // Runs one executing cycle through the model and checks all result ports.
  task automatic runExec(input string req, input logic [3:0] op, input logic execExp);
    logic [17:0] m;
    m = aluModel(op, aWord[15:0], bWord[15:0], mStatus);
    step();
    if (execExp) begin
      mData = m[15:0];
      if (m[17]) mStatus = m[16];
    end
    chkEq(req, {31'b0, resValid}, {31'b0, execExp});
    chkEq(req, {16'b0, resData}, {16'b0, mData});
    chkEq(req, {31'b0, statusOut}, {31'b0, mStatus});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; runEn = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    aWord = '0; bWord = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1: reset state
    chkEq("R1 resValid", {31'b0, resValid}, 0);
    chkEq("R1 resData", {16'b0, resData}, 0);
    chkEq("R1 statusOut", {31'b0, statusOut}, 0);
    chkEq("R1 curSlot", {29'b0, curSlot}, 0);
    // R1: cleared table never executes and stays in slot 0
    runEn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      aWord = {4'hF, 1'b1, 16'h1234}; bWord = {4'hF, 1'b1, 16'h4321};
      step();
      chkEq("R1 cleared slot no exec", {31'b0, resValid}, 0);
      chkEq("R1 cleared slot branch", {29'b0, curSlot}, 0);
    end

    // R4 R5 R6 R10: sweep every opcode with always-true condition
    for (int op = 0; op < 16; op++) begin
      runEn = 1'b0; step();
      loadSlot(0, mkInstr(op, 1, 0, 0, 0, 0, 0, 0, 0));
      runEn = 1'b1;
      for (int i = 0; i < 32; i++) begin
        aWord = {4'(i), i[0], patA(i)};
        bWord = {4'(i >> 1), i[1], patB(i)};
        if (op < 4)      runExec("R4,R10 arith", op[3:0], 1'b1);
        else if (op < 8) runExec("R5,R10 logic/select", op[3:0], 1'b1);
        else if (op < 12) runExec("R6,R10 shift/rotate", op[3:0], 1'b1);
        else             runExec("R5,R10 pass", op[3:0], 1'b1);
      end
    end

    // R7 R9: condition source sweep with ADD
    for (int sel = 0; sel < 16; sel++) begin
      for (int inv = 0; inv < 2; inv++) begin
        runEn = 1'b0; step();
        loadSlot(0, mkInstr(0, sel, inv, 0, 0, 0, 0, 0, 0));
        runEn = 1'b1;
        for (int i = 0; i < 6; i++) begin
          logic [17:0] m; logic e; logic [15:0] a;
          a = patA(i + sel + 5);
          aWord = {4'(i * 5 + sel), i[0], a};
          bWord = {4'(i * 3 + inv), i[1], (i[0] == 1'b0) ? (16'd0 - a) : patB(i + 7)};
          m = aluModel(4'd0, aWord[15:0], bWord[15:0], mStatus);
          e = srcModel(sel, aWord, bWord, mStatus, m[15:0], m[16]) ^ inv[0];
          runExec("R7,R9 conditional", 4'd0, e);
        end
      end
    end

    // R8: branch on a control bits, successors (3k+j+1) mod 8
    runEn = 1'b0; step();
    for (int k = 0; k < 8; k++)
      loadSlot(k, mkInstr(6, 1, 0, 9, 8, (3*k+1)%8, (3*k+2)%8, (3*k+3)%8, (3*k+4)%8));
    runEn = 1'b1;
    chkEq("R3 start slot", {29'b0, curSlot}, 0);
    begin
      int eSlot = 0;
      for (int i = 0; i < 64; i++) begin
        int idx;
        aWord = {4'(i * 7 + i / 5), 1'b1, patA(i)};
        bWord = {4'(i), 1'b0, patB(i)};
        idx = int'(aWord[18:17]);
        step();
        eSlot = (3 * eSlot + idx + 1) % 8;
        chkEq("R8 branch on ctrl", {29'b0, curSlot}, eSlot);
        chkEq("R8 xor result", {16'b0, resData}, {16'b0, aWord[15:0] ^ bWord[15:0]});
      end
      mData = aWord[15:0] ^ bWord[15:0];
    end
    // R3: dropping run parks in slot 0 and clears valid
    runEn = 1'b0; step();
    chkEq("R3 parked slot", {29'b0, curSlot}, 0);
    chkEq("R3 parked valid", {31'b0, resValid}, 0);

    // R8 R7: branch on result-zero and b valid, condition on a valid
    for (int k = 0; k < 8; k++)
      loadSlot(k, mkInstr(6, 2, 0, 5, 3, (k+5)%8, (k+2)%8, (k+7)%8, (k+1)%8));
    runEn = 1'b1;
    begin
      int eSlot = 0;
      for (int i = 0; i < 48; i++) begin
        int idx; logic z; logic [15:0] a;
        a = patA(i + 3);
        aWord = {4'(i), i[1], a};
        bWord = {4'(i), i[2], (i % 3 == 0) ? a : patB(i)};
        z = (aWord[15:0] ^ bWord[15:0]) == 16'd0;
        idx = {z, bWord[16]};
        step();
        eSlot = (eSlot + ((idx == 0) ? 5 : (idx == 1) ? 2 : (idx == 2) ? 7 : 1)) % 8;
        if (aWord[16]) mData = aWord[15:0] ^ bWord[15:0];
        chkEq("R8 branch regardless of exec", {29'b0, curSlot}, eSlot);
        chkEq("R7 valid follows cond", {31'b0, resValid}, {31'b0, aWord[16]});
        chkEq("R7 data hold", {16'b0, resData}, {16'b0, mData});
      end
    end

    // R2: writes while running are ignored
    runEn = 1'b0; step();
    loadSlot(0, mkInstr(4, 1, 0, 0, 0, 0, 0, 0, 0));
    runEn = 1'b1;
    aWord = {5'b0, 16'hF0F0}; bWord = {5'b0, 16'h0FF0};
    cfgWe = 1'b1; cfgAddr = 3'd0; cfgData = mkInstr(5, 1, 0, 0, 0, 0, 0, 0, 0);
    step();
    chkEq("R2 write ignored while running", {16'b0, resData}, 32'h00F0);
    step();
    chkEq("R2 write ignored while running", {16'b0, resData}, 32'h00F0);
    cfgWe = 1'b0; runEn = 1'b0; step();
    runEn = 1'b1; aWord = {5'b0, 16'hFF00}; bWord = {5'b0, 16'h0F0F};
    step();
    chkEq("R2 slot kept AND", {16'b0, resData}, 32'h0F00);
    runEn = 1'b0; step();
    loadSlot(0, mkInstr(5, 1, 0, 0, 0, 0, 0, 0, 0));
    runEn = 1'b1;
    step();
    chkEq("R2 write while stopped", {16'b0, resData}, 32'hFF0F);
    runEn = 1'b0; step();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule